// File: doc/BRIEF.md
# Bidirectional Row Scan Shift Register

This block is the row-scan side of a dot-matrix display driver. A register of `STAGES` single-bit stages holds the select pattern for the panel rows. Each stage, combined with the frame-inversion input and an active-low blanking input, is turned into a 2-bit drive-level code. The register advances by one stage on each falling edge of a latch pulse. That pulse is sampled with the system clock, and its falling edge is found by a synchronous detector.

A direction input sets the way data moves. It also decides which of the two serial pins receives data and which one drives data out. A split input picks the chain layout: either one chain as long as the whole register, or two half-length chains. In the split layout, the second chain takes its data from a separate auxiliary input. Several instances form one long scan chain when the serial output of each is wired to the serial input of the next.

The serial pins are modelled as separate input, output and output-enable signals, so that no tristate port is needed.

Top module: `row_scan_driver`

## Requirements
- R1: After reset every stage is 0, both serial outputs are 0, and with blanking inactive and `fr_i`=0 every stage's level code is 1.
- R2: The register changes only at the clock edge that samples `lp_i` low after it was sampled high, while `blank_n_i` is high. If `lp_i` is held high or held low, the stages and the serial output keep their values.
- R3: With `dir_i`=1 and `dual_i`=0, stage k+1 takes the old value of stage k, and stage 0 takes `ser1_i`.
- R4: With `dir_i`=0 and `dual_i`=0, stage k takes the old value of stage k+1, and stage STAGES-1 takes `ser2_i`.
- R5: With `dual_i`=0, `aux_i` has no effect on any stage.
- R6: With `dir_i`=1 and `dual_i`=1, stages 0..H-1 (where H=STAGES/2) shift upward fed from `ser1_i`. Stages H..STAGES-1 shift upward fed from `aux_i`. The old value of stage H-1 is dropped.
- R7: With `dir_i`=0 and `dual_i`=1, stages STAGES-1..H shift downward fed from `ser2_i`. Stages H-1..0 shift downward fed from `aux_i`. The old value of stage H is dropped.
- R8: The level code of a stage follows this table:
  - `fr_i`=0 and stage 0 gives 1 (middle-low level).
  - `fr_i`=0 and stage 1 gives 3 (highest level).
  - `fr_i`=1 and stage 0 gives 2 (middle-high level).
  - `fr_i`=1 and stage 1 gives 0 (lowest level).
  Stage k's code sits in bits [2k+1:2k] of `level_o`.
- R9: While `blank_n_i`=0:
  - every level code is 0;
  - all stages and the serial output are cleared at each clock;
  - no shift takes place.
  After release, the first detected latch-pulse fall shifts.
- R10: `ser1_oe`=1 exactly when `dir_i`=0, and `ser2_oe`=1 exactly when `dir_i`=1. A serial output whose enable is 0 drives 0.
- R11: On each shift, the serial output takes the value that stage STAGES-1 held before the shift when `dir_i`=1, or the value that stage 0 held when `dir_i`=0. It holds that value until the next shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_i | input | 1 | Latch pulse; a falling edge advances the register |
| dir_i | input | 1 | 1: data moves toward higher stages; 0: toward lower stages |
| dual_i | input | 1 | 1: two half-length chains; 0: one full chain |
| blank_n_i | input | 1 | Active-low display blanking |
| fr_i | input | 1 | Frame inversion |
| ser1_i | input | 1 | Serial pin 1 input (used as data input when `dir_i`=1) |
| ser1_o | output | 1 | Serial pin 1 output value |
| ser1_oe | output | 1 | Serial pin 1 output enable |
| ser2_i | input | 1 | Serial pin 2 input (used as data input when `dir_i`=0) |
| ser2_o | output | 1 | Serial pin 2 output value |
| ser2_oe | output | 1 | Serial pin 2 output enable |
| aux_i | input | 1 | Second-chain data input in split layout |
| level_o | output | 2*STAGES | Drive-level code, 2 bits per stage |

## Verification
On every cycle, the assertions check the following:
- that the register stays still unless a latch-pulse fall is seen;
- which input enters the register at the end stages and at the split point;
- that the serial output takes the bit leaving the chain;
- that blanking clears the register and forces every level code to 0;
- that exactly one serial pin is driving.

Other behaviours can only be shown by the bench scenarios, which compare the full level vector with a reference model. These are:
- that every interior stage moves by exactly one place;
- that the split layout drops the bit crossing the midpoint;
- that `aux_i` has no effect in the single-chain layout;
- the complete level table under both frame phases;
- that shifting resumes at the first latch-pulse fall after blanking is released.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic [1:0] {
    LVL_V5  = 2'd0,
    LVL_V43 = 2'd1,
    LVL_V12 = 2'd2,
    LVL_V0  = 2'd3
  } drive_lvl_e;

  // Row-side level selection; blanking wins over everything.
  function automatic drive_lvl_e row_level(input logic stage_bit,
                                           input logic frame_inv,
                                           input logic active);
    drive_lvl_e lvl;
    if (!active) begin
      lvl = LVL_V5;
    end else begin
      case ({frame_inv, stage_bit})
        2'b00:   lvl = LVL_V43;
        2'b01:   lvl = LVL_V0;
        2'b10:   lvl = LVL_V12;
        default: lvl = LVL_V5;
      endcase
    end
    return lvl;
  endfunction

endpackage

// File: rtl/rsd_rst_sync.sv
module rsd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rsd_edge_det.sv
module rsd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fall_o
);
  logic level_q;
  logic level_d;

  always_comb level_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign fall_o = level_q & ~level_i;
endmodule

// File: rtl/rsd_shift_core.sv
module rsd_shift_core #(
  parameter int STAGES = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              clear,
  input  logic              dir_up,
  input  logic              split,
  input  logic              feed_lo,
  input  logic              feed_hi,
  input  logic              feed_aux,
  output logic [STAGES-1:0] stage_o,
  output logic              sout_o
);
  localparam int HALF = STAGES / 2;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic [STAGES-1:0] src_up;
  logic [STAGES-1:0] src_dn;
  logic              sout_q;
  logic              sout_d;

  // Per-stage source when moving toward higher / lower indices.
  for (genvar k = 0; k < STAGES; k++) begin : g_src
    if (k == 0) begin : g_up_end
      assign src_up[k] = feed_lo;
    end else if (k == HALF) begin : g_up_mid
      assign src_up[k] = split ? feed_aux : stage_q[k-1];
    end else begin : g_up_mid_no
      assign src_up[k] = stage_q[k-1];
    end

    if (k == STAGES - 1) begin : g_dn_end
      assign src_dn[k] = feed_hi;
    end else if (k == HALF - 1) begin : g_dn_mid
      assign src_dn[k] = split ? feed_aux : stage_q[k+1];
    end else begin : g_dn_mid_no
      assign src_dn[k] = stage_q[k+1];
    end
  end

  always_comb begin
    if (clear) begin
      stage_d = '0;
      sout_d  = 1'b0;
    end else if (shift_en) begin
      stage_d = dir_up ? src_up : src_dn;
      sout_d  = dir_up ? stage_q[STAGES-1] : stage_q[0];
    end else begin
      stage_d = stage_q;
      sout_d  = sout_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      sout_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      sout_q  <= sout_d;
    end
  end

  assign stage_o = stage_q;
  assign sout_o  = sout_q;
endmodule

// File: rtl/rsd_level_map.sv
module rsd_level_map #(
  parameter int STAGES = 160
) (
  input  logic [STAGES-1:0]   stage_i,
  input  logic                fr_i,
  input  logic                active_i,
  output logic [2*STAGES-1:0] level_o
);
  import rsd_pkg::*;

  for (genvar k = 0; k < STAGES; k++) begin : g_lvl
    drive_lvl_e lvl;
    always_comb lvl = row_level(stage_i[k], fr_i, active_i);
    assign level_o[2*k +: 2] = lvl;
  end
endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver #(
  parameter int STAGES = 160
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lp_i,
  input  logic                dir_i,
  input  logic                dual_i,
  input  logic                blank_n_i,
  input  logic                fr_i,
  input  logic                ser1_i,
  output logic                ser1_o,
  output logic                ser1_oe,
  input  logic                ser2_i,
  output logic                ser2_o,
  output logic                ser2_oe,
  input  logic                aux_i,
  output logic [2*STAGES-1:0] level_o
);
  logic              rst_sync_n;
  logic              lp_fall;
  logic              shift_en;
  logic              clear;
  logic [STAGES-1:0] stage_q;
  logic              sout_q;

  rsd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rsd_edge_det u_lp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .level_i (lp_i),
    .fall_o  (lp_fall)
  );

  assign clear    = ~blank_n_i;
  assign shift_en = lp_fall & blank_n_i;

  rsd_shift_core #(.STAGES(STAGES)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_en),
    .clear    (clear),
    .dir_up   (dir_i),
    .split    (dual_i),
    .feed_lo  (ser1_i),
    .feed_hi  (ser2_i),
    .feed_aux (aux_i),
    .stage_o  (stage_q),
    .sout_o   (sout_q)
  );

  rsd_level_map #(.STAGES(STAGES)) u_map (
    .stage_i  (stage_q),
    .fr_i     (fr_i),
    .active_i (blank_n_i),
    .level_o  (level_o)
  );

  assign ser1_oe = ~dir_i;
  assign ser2_oe = dir_i;
  assign ser1_o  = ~dir_i & sout_q;
  assign ser2_o  = dir_i & sout_q;
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int STAGES = 160
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lp_i,
  input logic                dir_i,
  input logic                dual_i,
  input logic                blank_n_i,
  input logic                ser1_i,
  input logic                ser2_i,
  input logic                aux_i,
  input logic                ser1_o,
  input logic                ser2_o,
  input logic                ser1_oe,
  input logic                ser2_oe,
  input logic [STAGES-1:0]   stage_q,
  input logic [2*STAGES-1:0] level_o
);
  localparam int HALF = STAGES / 2;

  logic lp_d;
  logic fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_d <= 1'b0;
    else        lp_d <= lp_i;
  end

  assign fall_seen = lp_d & ~lp_i;

  // R2
  a_r2_still_without_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_seen && blank_n_i) |=> $stable(stage_q));

  // R3
  a_r3_entry_upward: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_seen && blank_n_i && dir_i) |=> stage_q[0] == $past(ser1_i));

  // R4
  a_r4_entry_downward: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_seen && blank_n_i && !dir_i) |=> stage_q[STAGES-1] == $past(ser2_i));

  // R6
  a_r6_split_aux_up: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_seen && blank_n_i && dir_i && dual_i) |=> stage_q[HALF] == $past(aux_i));

  // R7
  a_r7_split_aux_down: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_seen && blank_n_i && !dir_i && dual_i) |=> stage_q[HALF-1] == $past(aux_i));

  // R9
  a_r9_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n_i |=> stage_q == '0);

  // R9
  a_r9_blank_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n_i |-> level_o == '0);

  // R10
  a_r10_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ser1_oe, ser2_oe}) == 1);

  // R10
  a_r10_idle_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser1_oe |-> !ser1_o) and (!ser2_oe |-> !ser2_o));

  // R11
  a_r11_sout_upward: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_seen && blank_n_i && dir_i) |=> ser2_o == $past(stage_q[STAGES-1]));

  // R11
  a_r11_sout_downward: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_seen && blank_n_i && !dir_i) |=> ser1_o == $past(stage_q[0]));
endmodule

bind row_scan_driver rsd_checker #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .lp_i      (lp_i),
  .dir_i     (dir_i),
  .dual_i    (dual_i),
  .blank_n_i (blank_n_i),
  .ser1_i    (ser1_i),
  .ser2_i    (ser2_i),
  .aux_i     (aux_i),
  .ser1_o    (ser1_o),
  .ser2_o    (ser2_o),
  .ser1_oe   (ser1_oe),
  .ser2_oe   (ser2_oe),
  .stage_q   (stage_q),
  .level_o   (level_o)
);

// File: tb/tb_row_scan_driver.sv
module tb_row_scan_driver;
  localparam int STAGES   = 160;
  localparam int HALF     = STAGES / 2;
  localparam int CLK_PER  = 10;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n, lp_i, dir_i, dual_i, blank_n_i, fr_i;
  logic ser1_i, ser2_i, aux_i;
  logic ser1_o, ser1_oe, ser2_o, ser2_oe;
  logic [2*STAGES-1:0] level_o;

  int  total = 0;
  int  bad   = 0;
  bit  mdl [STAGES];
  bit  mout;

  always #(CLK_PER/2) clk = ~clk;

  row_scan_driver #(.STAGES(STAGES)) dut (
    .clk(clk), .rst_n(rst_n), .lp_i(lp_i), .dir_i(dir_i), .dual_i(dual_i),
    .blank_n_i(blank_n_i), .fr_i(fr_i),
    .ser1_i(ser1_i), .ser1_o(ser1_o), .ser1_oe(ser1_oe),
    .ser2_i(ser2_i), .ser2_o(ser2_o), .ser2_oe(ser2_oe),
    .aux_i(aux_i), .level_o(level_o)
  );

  function automatic logic [1:0] exp_code(bit b, logic fr, logic on);
    if (!on)     return 2'd0;
    if (fr == 0) return b ? 2'd3 : 2'd1;
    return b ? 2'd0 : 2'd2;
  endfunction

  task automatic check(string req);
    logic [2*STAGES-1:0] exp;
    logic e1, e2;
    for (int k = 0; k < STAGES; k++) exp[2*k +: 2] = exp_code(mdl[k], fr_i, blank_n_i);
    e1 = dir_i ? 1'b0 : mout;
    e2 = dir_i ? mout : 1'b0;
    total++;
    if (level_o !== exp) begin
      bad++;
      $display("FAIL %s levels: actual=%h expected=%h", req, level_o, exp);
    end
    total++;
    if (ser1_o !== e1 || ser2_o !== e2 || ser1_oe !== !dir_i || ser2_oe !== dir_i) begin
      bad++;
      $display("FAIL %s serial: actual o=%b%b oe=%b%b expected o=%b%b oe=%b%b",
               req, ser1_o, ser2_o, ser1_oe, ser2_oe, e1, e2, !dir_i, dir_i);
    end
  endtask

  function automatic void model_shift(bit d, bit sp, bit a, bit b, bit x);
    bit old [STAGES];
    old = mdl;
    if (d) begin
      mout = old[STAGES-1];
      for (int k = 0; k < STAGES; k++)
        mdl[k] = (k == 0) ? a : (sp && k == HALF) ? x : old[k-1];
    end else begin
      mout = old[0];
      for (int k = 0; k < STAGES; k++)
        mdl[k] = (k == STAGES-1) ? b : (sp && k == HALF-1) ? x : old[k+1];
    end
  endfunction

  // One latch pulse: high for a cycle, then low; result visible one negedge later.
  task automatic pulse(bit d, bit sp, bit a, bit b, bit x);
    @(negedge clk);
    dir_i = d; dual_i = sp; ser1_i = a; ser2_i = b; aux_i = x; lp_i = 1'b1;
    @(negedge clk);
    lp_i = 1'b0;
    @(negedge clk);
    if (blank_n_i) model_shift(d, sp, a, b, x);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3a_77e5));
    rst_n = 1'b0; lp_i = 1'b0; dir_i = 1'b1; dual_i = 1'b0; blank_n_i = 1'b1;
    fr_i = 1'b0; ser1_i = 1'b0; ser2_i = 1'b0; aux_i = 1'b0;
    for (int k = 0; k < STAGES; k++) mdl[k] = 1'b0;
    mout = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset");

    // R3 single upward, ones and zeros
    pulse(1, 0, 1, 0, 0); check("R3 up first");
    pulse(1, 0, 0, 1, 1); check("R3 up second / R5 aux ignored");
    pulse(1, 0, 1, 0, 1); check("R3 up third");

    // R2 no shift with lp held high, then held low
    @(negedge clk); lp_i = 1'b1; ser1_i = 1'b0; ser2_i = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 lp held high");
    lp_i = 1'b0; @(negedge clk); model_shift(dir_i, dual_i, 0, 1, aux_i);
    ser1_i = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 lp held low after one fall");

    // R8 level table under both frame phases
    fr_i = 1'b1; @(negedge clk); check("R8 fr=1");
    fr_i = 1'b0; @(negedge clk); check("R8 fr=0");

    // R4 single downward and R11 leaving bit
    for (int i = 0; i < STAGES + 3; i++) pulse(0, 0, 0, i[0], 1);
    check("R4 R11 downward full pass");

    // R6 / R7 split layout
    for (int i = 0; i < 6; i++) begin pulse(1, 1, 1, 0, i[1]); check("R6 split up"); end
    for (int i = 0; i < 6; i++) begin pulse(0, 1, 0, 1, i[0]); check("R7 split down"); end

    // R5 aux toggled in single layout
    for (int i = 0; i < HALF + 2; i++) pulse(1, 0, i[2], 0, ~i[0]);
    check("R5 aux ignored in single chain");

    // R9 blanking: outputs lowest, cleared, fall ignored, resume after release
    @(negedge clk); blank_n_i = 1'b0;
    for (int k = 0; k < STAGES; k++) mdl[k] = 1'b0;
    mout = 1'b0;
    @(negedge clk); check("R9 blanked levels");
    pulse(1, 0, 1, 1, 1); check("R9 fall while blanked ignored");
    @(negedge clk); blank_n_i = 1'b1;
    @(negedge clk); check("R9 cleared after release");
    pulse(1, 0, 1, 0, 0); check("R9 first fall after release shifts");

    // R10 and mixed random operation
    for (int i = 0; i < 400; i++) begin
      bit d, sp;
      d  = 1'($urandom);
      sp = 1'($urandom);
      fr_i = 1'($urandom);
      pulse(d, sp, 1'($urandom), 1'($urandom), 1'($urandom));
      check(sp ? (d ? "R6 R10 random" : "R7 R10 random") : (d ? "R3 R11 random" : "R4 R11 random"));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule